// File: doc/BRIEF.md
# Reset Cause Capture Register

This block keeps a record of the reasons the chip has been reset. Each cause has its own flag bit. A flag is set by its cause and then stays set, so several flags can be set together after a run of resets. Software reads the register once to learn every cause seen since its last read. That same read clears all flags in one step. Power-on starts the register with only the power-on flag set.

Two of the causes are detected inside the block, from qualifiers the core supplies:

- **Illegal opcode.** The decoder marks each decoded opcode as legal or not. It also marks whether the opcode is a stop instruction, which counts as illegal when a configuration bit forbids stopping.
- **Illegal address.** The fetch unit marks whether each fetch is an opcode fetch or a data fetch. The memory map says whether the address is populated. Only an opcode fetch from an empty address counts.

Both causes also raise a one-cycle reset request toward the reset sequencer. The low-voltage cause arrives as a ready-made pulse.

The pad cause works from the reset pin. After the internal reset stops pulling the pin low, the block waits a fixed number of cycles and then samples the pad. A pad that is still low sets the pin flag.

Top module: `rst_cause_log`

## Requirements
- R1: After power-on reset, the first read returns 0x80: bit 7 (power-on) set and all other bits 0. `rdData` itself is 0 while in reset.
- R2: `rdData` is updated at the clock edge that samples `rdStrobe` high. It takes the flag value from just before that edge and holds that value until the next read.
- R3: A read clears every flag at the same edge, so a following read with no new cause returns 0x00.
- R4: Causes that occur with no read in between all stay set. A lower-voltage event, an illegal opcode, an illegal address, the power-on flag and the pin flag together read as 0xDA.
- R5: A cause whose set strobe coincides with a read is not lost. It is absent from that read's data and present in the next read.
- R6: A decoded opcode that is marked not legal sets bit 4. In the cycle after the flag is set, `rstReq` is high for exactly one cycle.
- R7: A stop opcode sets bit 4 when `stopEnable` is 0. When `stopEnable` is 1, the same stop opcode sets no flag.
- R8: An opcode fetch from an unmapped address sets bit 3 and pulses `rstReq` the next cycle. A data fetch from an unmapped address, or an opcode fetch from a mapped address, sets no flag and raises no request.
- R9: A pulse on `lowVoltEvt` sets bit 1.
- R10: Edge k is the first clock edge that samples `pinDriveLow` low after it was high. The pad is judged at edge k+PIN_DELAY (32 by default). Bit 6 is set at that edge only if `pinLevel` is 0 then. A pad that was low earlier in the window but is high at that edge sets nothing.
- R11: Bits 5, 2 and 0 always read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| rdStrobe | input | 1 | One-cycle read request; captures and clears the flags |
| lowVoltEvt | input | 1 | Pulse from the low-voltage sequencer |
| opStrobe | input | 1 | A decoded opcode is presented this cycle |
| opLegal | input | 1 | Opcode belongs to the instruction set |
| opIsStop | input | 1 | Opcode is the stop instruction |
| stopEnable | input | 1 | Configuration bit; 0 makes stop illegal |
| fetchValid | input | 1 | A memory fetch is presented this cycle |
| fetchIsOpcode | input | 1 | 1 for an opcode fetch, 0 for a data fetch |
| addrMapped | input | 1 | Fetch address is populated in the memory map |
| pinDriveLow | input | 1 | Internal reset is pulling the reset pin low |
| pinLevel | input | 1 | Sampled pad level of the reset pin |
| rdData | output | 8 | Flag value captured by the last read |
| rstReq | output | 1 | One-cycle reset request on an illegal opcode or address |

## Verification
A read and a new cause can land on the same clock edge. This is where a careless clear would lose the cause. The bench provokes it in two ways. First, it applies `lowVoltEvt` and `rdStrobe` in the same cycle. Second, it times a read to be sampled exactly at the pad-judging edge, 32 cycles after the pin is released. In both cases the scoreboard expects the coinciding read to lack the new flag, and the next read to show it alone.

// File: rtl/rst_cause_pkg.sv
package rst_cause_pkg;
  localparam int REG_W    = 8;
  localparam int BIT_POR  = 7;
  localparam int BIT_PIN  = 6;
  localparam int BIT_ILOP = 4;
  localparam int BIT_ILAD = 3;
  localparam int BIT_LVI  = 1;
  localparam logic [REG_W-1:0] FLAG_MASK =
    (REG_W'(1) << BIT_POR) | (REG_W'(1) << BIT_PIN) | (REG_W'(1) << BIT_ILOP) |
    (REG_W'(1) << BIT_ILAD) | (REG_W'(1) << BIT_LVI);
  localparam logic [REG_W-1:0] POR_VALUE = REG_W'(1) << BIT_POR;

  typedef struct packed {
    logic clr;
    logic setPin;
    logic setIlop;
    logic setIlad;
    logic setLvi;
  } strobe_t;
endpackage

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl
  import rst_cause_pkg::*;
#(
  parameter int PIN_DELAY = 32
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    rdStrobe,
  input  logic    lowVoltEvt,
  input  logic    opStrobe,
  input  logic    opLegal,
  input  logic    opIsStop,
  input  logic    stopEnable,
  input  logic    fetchValid,
  input  logic    fetchIsOpcode,
  input  logic    addrMapped,
  input  logic    pinDriveLow,
  input  logic    pinLevel,
  output strobe_t strb,
  output logic    rstReq
);
  localparam int CNT_W = $clog2(PIN_DELAY + 1);

  logic             driveQ;
  logic [CNT_W-1:0] cnt;
  logic             releaseSeen;
  logic             sampleNow;
  logic             badOpcode;
  logic             badAddr;

  // opcode and fetch qualification
  always_comb begin
    badOpcode = opStrobe && (!opLegal || (opIsStop && !stopEnable));
    badAddr   = fetchValid && fetchIsOpcode && !addrMapped;
  end

  // pad-sampling window after the pin is released
  assign releaseSeen = driveQ && !pinDriveLow;
  assign sampleNow   = (cnt == CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      driveQ <= 1'b1;
      cnt    <= '0;
    end else begin
      driveQ <= pinDriveLow;
      if (pinDriveLow)      cnt <= '0;
      else if (releaseSeen) cnt <= CNT_W'(PIN_DELAY);
      else if (cnt != '0)   cnt <= cnt - CNT_W'(1);
    end
  end

  always_comb begin
    strb.clr     = rdStrobe;
    strb.setLvi  = lowVoltEvt;
    strb.setIlop = badOpcode;
    strb.setIlad = badAddr;
    strb.setPin  = sampleNow && !pinLevel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rstReq <= 1'b0;
    else       rstReq <= badOpcode || badAddr;
  end

  // R10
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CNT_W'(PIN_DELAY));

  // R10
  window_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (driveQ && !pinDriveLow) |=> cnt == CNT_W'(PIN_DELAY));

  // R6
  req_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setIlop || strb.setIlad) |=> rstReq);

  // R8
  data_fetch_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!fetchValid || !fetchIsOpcode) |-> !strb.setIlad);
endmodule

// File: rtl/rst_cause_dp.sv
module rst_cause_dp
  import rst_cause_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  output logic [REG_W-1:0] rdData
);
  logic [REG_W-1:0] flags;
  logic [REG_W-1:0] setVec;
  logic [REG_W-1:0] kept;

  always_comb begin
    setVec           = '0;
    setVec[BIT_PIN]  = strb.setPin;
    setVec[BIT_ILOP] = strb.setIlop;
    setVec[BIT_ILAD] = strb.setIlad;
    setVec[BIT_LVI]  = strb.setLvi;
    kept             = strb.clr ? '0 : flags;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flags  <= POR_VALUE;
      rdData <= '0;
    end else begin
      flags <= (kept | setVec) & FLAG_MASK;
      if (strb.clr) rdData <= flags;
    end
  end

  // R3
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clr && !strb.setPin && !strb.setIlop && !strb.setIlad && !strb.setLvi)
      |=> flags == '0);

  // R4
  sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clr |=> (flags & $past(flags)) == $past(flags));

  // R2
  rd_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clr |=> rdData == $past(flags));

  // R2
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clr |=> $stable(rdData));

  // R5
  same_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clr && strb.setLvi) |=> flags[BIT_LVI]);

  // R11
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flags & ~FLAG_MASK) == '0);
endmodule

// File: rtl/rst_cause_log.sv
module rst_cause_log
  import rst_cause_pkg::*;
#(
  parameter int PIN_DELAY = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rdStrobe,
  input  logic             lowVoltEvt,
  input  logic             opStrobe,
  input  logic             opLegal,
  input  logic             opIsStop,
  input  logic             stopEnable,
  input  logic             fetchValid,
  input  logic             fetchIsOpcode,
  input  logic             addrMapped,
  input  logic             pinDriveLow,
  input  logic             pinLevel,
  output logic [REG_W-1:0] rdData,
  output logic             rstReq
);
  strobe_t strb;

  rst_cause_ctrl #(.PIN_DELAY(PIN_DELAY)) i_ctrl (
    .clk(clk), .rstN(rstN), .rdStrobe(rdStrobe), .lowVoltEvt(lowVoltEvt),
    .opStrobe(opStrobe), .opLegal(opLegal), .opIsStop(opIsStop),
    .stopEnable(stopEnable), .fetchValid(fetchValid),
    .fetchIsOpcode(fetchIsOpcode), .addrMapped(addrMapped),
    .pinDriveLow(pinDriveLow), .pinLevel(pinLevel),
    .strb(strb), .rstReq(rstReq)
  );

  rst_cause_dp i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rdData(rdData)
  );
endmodule

// File: tb/test_rst_cause_log.sv
module test_rst_cause_log;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rdStrobe = 0, lowVoltEvt = 0, opStrobe = 0, opLegal = 1, opIsStop = 0;
  logic       stopEnable = 1, fetchValid = 0, fetchIsOpcode = 0, addrMapped = 1;
  logic       pinDriveLow = 1, pinLevel = 1;
  logic [7:0] rdData;
  logic       rstReq;

  int checks = 0;
  int fails  = 0;
  logic [7:0] expQ[$];
  string      tagQ[$];
  bit         done = 0;

  always #4 clk = ~clk;

  rst_cause_log i_rst_cause_log (
    .clk(clk), .rstN(rstN), .rdStrobe(rdStrobe), .lowVoltEvt(lowVoltEvt),
    .opStrobe(opStrobe), .opLegal(opLegal), .opIsStop(opIsStop),
    .stopEnable(stopEnable), .fetchValid(fetchValid),
    .fetchIsOpcode(fetchIsOpcode), .addrMapped(addrMapped),
    .pinDriveLow(pinDriveLow), .pinLevel(pinLevel),
    .rdData(rdData), .rstReq(rstReq)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  // driver: queue the expected read value, then issue the strobe
  task automatic readReg(string tag, logic [7:0] exp);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    @(posedge clk); #1 rdStrobe = 1;
    @(posedge clk); #1 rdStrobe = 0;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // monitor: compares each read result one negedge after the strobe was seen
  initial begin
    bit pend = 0;
    forever begin
      @(negedge clk);
      if (pend) begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(t, rdData, e);
        check("R11 unused bits", rdData & 8'h25, 8'h00);
      end
      pend = rdStrobe;
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rdData in reset", rdData, 8'h00);
    @(posedge clk); #1 rstN = 1;
    idle(2);
    readReg("R1 power-on value", 8'h80);
    readReg("R3 cleared after read", 8'h00);
    readReg("R2 read holds value", 8'h00);

    // R9 and R6, accumulating (R4)
    @(posedge clk); #1 lowVoltEvt = 1;
    @(posedge clk); #1 lowVoltEvt = 0;
    @(posedge clk); #1 opStrobe = 1; opLegal = 0;
    @(posedge clk); #1 opStrobe = 0; opLegal = 1;
    @(negedge clk); check("R6 rstReq high", {7'd0, rstReq}, 8'h01);
    @(negedge clk); check("R6 rstReq one cycle", {7'd0, rstReq}, 8'h00);
    readReg("R4 R9 R6 accumulated", 8'h12);

    // R7 stop handling
    stopEnable = 1;
    @(posedge clk); #1 opStrobe = 1; opIsStop = 1;
    @(posedge clk); #1 opStrobe = 0;
    @(negedge clk); check("R7 no rstReq when stop enabled", {7'd0, rstReq}, 8'h00);
    readReg("R7 stop allowed", 8'h00);
    stopEnable = 0;
    @(posedge clk); #1 opStrobe = 1;
    @(posedge clk); #1 opStrobe = 0; opIsStop = 0;
    readReg("R7 stop illegal", 8'h10);
    stopEnable = 1;

    // R8 fetch qualification
    @(posedge clk); #1 fetchValid = 1; fetchIsOpcode = 0; addrMapped = 0;
    @(posedge clk); #1 fetchValid = 0;
    @(negedge clk); check("R8 no rstReq data fetch", {7'd0, rstReq}, 8'h00);
    @(posedge clk); #1 fetchValid = 1; fetchIsOpcode = 1; addrMapped = 1;
    @(posedge clk); #1 fetchValid = 0;
    readReg("R8 data or mapped fetch quiet", 8'h00);
    @(posedge clk); #1 fetchValid = 1; fetchIsOpcode = 1; addrMapped = 0;
    @(posedge clk); #1 fetchValid = 0; addrMapped = 1;
    @(negedge clk); check("R8 rstReq opcode fetch", {7'd0, rstReq}, 8'h01);
    readReg("R8 unmapped opcode fetch", 8'h08);

    // R5 read and event in the same cycle
    @(posedge clk); #1 opStrobe = 1; opLegal = 0;
    @(posedge clk); #1 opStrobe = 0; opLegal = 1;
    expQ.push_back(8'h10); tagQ.push_back("R5 coincident read excludes event");
    @(posedge clk); #1 rdStrobe = 1; lowVoltEvt = 1;
    @(posedge clk); #1 rdStrobe = 0; lowVoltEvt = 0;
    @(negedge clk);
    readReg("R5 coincident event kept", 8'h02);

    // R10 pad low at the judging edge
    pinLevel = 0;
    @(posedge clk); #1 pinDriveLow = 0;
    idle(40);
    pinLevel = 1;
    readReg("R10 pad low sets flag", 8'h40);

    // R10 pad low early in window but high at the judging edge
    @(posedge clk); #1 pinDriveLow = 1; pinLevel = 0;
    @(posedge clk); #1 pinDriveLow = 0;
    idle(20);
    pinLevel = 1;
    idle(20);
    readReg("R10 pad recovered no flag", 8'h00);

    // R10 with R5: read sampled on the judging edge itself
    @(posedge clk); #1 pinDriveLow = 1; pinLevel = 0;
    @(posedge clk); #1 pinDriveLow = 0;
    repeat (31) @(posedge clk);
    readReg("R10 read on judging edge", 8'h00);
    pinLevel = 1;
    readReg("R10 flag set at judging edge", 8'h40);

    // R4 all sources together, after a fresh power-on
    @(posedge clk); #1 rstN = 0; pinDriveLow = 1; pinLevel = 0;
    idle(2);
    @(posedge clk); #1 rstN = 1;
    @(posedge clk); #1 pinDriveLow = 0;
    @(posedge clk); #1 lowVoltEvt = 1;
    @(posedge clk); #1 lowVoltEvt = 0; opStrobe = 1; opLegal = 0;
    @(posedge clk); #1 opStrobe = 0; opLegal = 1;
    fetchValid = 1; fetchIsOpcode = 1; addrMapped = 0;
    @(posedge clk); #1 fetchValid = 0; addrMapped = 1;
    idle(40);
    pinLevel = 1;
    readReg("R4 all sources", 8'hDA);
    readReg("R3 all cleared", 8'h00);

    idle(2);
    done = 1;
    summary();
  end
endmodule